// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 64K words by 16 bits. The requester hands over one word access at a time on a valid/ready port: an address, a write flag, write data and a two-bit byte mask. The controller then walks the memory pins through a fixed sequence of phases. It drives the address, a low-active select and a high-active select, output enable, write enable, two low-active byte-lane enables and the data driver with its tristate control. For a read it returns the captured word with a single-cycle response pulse.

Every phase length is a whole number of system clocks. Each one is derived at elaboration from a nanosecond minimum and the clock period: the count is the ceiling of the quotient, and never less than one. At the default 10 ns clock, a write takes 6 busy cycles: one setup cycle, a 4-cycle strobe and one hold cycle. A read takes 8 busy cycles: a 6-cycle access phase and a 2-cycle bus release.

States: IDLE (ready, pins parked), WR_SETUP (select, lanes and driver on, write enable high), WR_STROBE (write enable low), WR_HOLD (write enable high again, driver and select kept), WR_RECOVER (pins parked until the write cycle minimum is met; skipped when its length is zero), RD_ACCESS (select, lanes and output enable low), RD_TURN (pins parked, driver held off while the memory floats its outputs). Transitions: IDLE to WR_SETUP or RD_ACCESS on an accepted request. WR_SETUP to WR_STROBE, WR_STROBE to WR_HOLD, WR_HOLD to WR_RECOVER or IDLE, WR_RECOVER to IDLE, RD_ACCESS to RD_TURN and RD_TURN to IDLE, each when its phase count runs out.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and straight after reset, mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_lb_n=1, mem_ub_n=1, mem_dq_oe=0, rsp_valid=0 and req_ready=1.
- R2: The memory is selected (mem_cs1_n=0 and mem_cs2=1) in every WR_SETUP, WR_STROBE, WR_HOLD and RD_ACCESS cycle. It is deselected (mem_cs1_n=1, mem_cs2=0) whenever req_ready is high: 6 selected cycles per write and 6 per read at defaults.
- R3: Byte mask bit 0 enables the lower lane (data bits 7:0, mem_lb_n low) and bit 1 the upper lane (bits 15:8, mem_ub_n low), only while selected. A write with mask 2'b00 leaves both lane enables high and changes no stored byte.
- R4: In a write, mem_oe_n stays high. mem_dq_oe is high in the cycle before mem_we_n falls and in the cycle after it rises. mem_we_n is low for max(ceil(tPWE), ceil(tSD), ceil(tAW)-1) cycles, which is 4 at defaults.
- R5: In a read, mem_oe_n is low for max(ceil(tAA), ceil(tDOE), ceil(tRC)) cycles (6 at defaults). The bus is sampled at the last of them. rsp_valid is high for exactly the next cycle, and bytes of disabled lanes read as zero.
- R6: After mem_oe_n rises, mem_dq_oe stays low for ceil(tHZOE) cycles (2 at defaults), before any new request is accepted.
- R7: req_ready is high only in IDLE. It stays low for 6 cycles after an accepted write and 8 after an accepted read at defaults, which keeps each access at least one full cycle time long.
- R8: A read returns, per enabled lane, the byte most recently written to that address and lane.
- R9: mem_we_n and mem_oe_n are never low together, and mem_dq_oe is never high while mem_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lanes: bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs1_n | output | 1 | Low-active select |
| mem_cs2 | output | 1 | High-active select |
| mem_oe_n | output | 1 | Output enable, low active |
| mem_we_n | output | 1 | Write enable, low active |
| mem_lb_n | output | 1 | Lower lane enable, low active |
| mem_ub_n | output | 1 | Upper lane enable, low active |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data received from the memory |
| mem_dq_oe | output | 1 | Tristate driver enable for mem_dq_out |

## Verification
The embedded properties watch, on every cycle, the pin relations that must never break. Write and output enable are never low together, and the driver never fights the memory's outputs. The driver brackets the write strobe on both sides, the response pulse lasts one cycle, and the pins stay parked while the block is idle. Phase lengths, the exact number of busy cycles, lane gating and the data itself can only be shown by the bench's scenarios. There, a pin-level memory model stores what the strobes actually write, and the returned words are compared against a request-level reference.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WR_SETUP   = 3'd1,
        ST_WR_STROBE  = 3'd2,
        ST_WR_HOLD    = 3'd3,
        ST_WR_RECOVER = 3'd4,
        ST_RD_ACCESS  = 3'd5,
        ST_RD_TURN    = 3'd6
    } bus_state_t;

    // Ceiling of ns / period, never below one cycle.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

    // R7: a loaded phase length is what the counter holds next cycle
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_wr,
    input  logic [LANES*8-1:0] wr_data,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] dq_in,
    output logic [LANES*8-1:0] dq_out,
    output logic [LANES*8-1:0] rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] wr_q;
        logic [7:0] rd_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_q <= '0;
                rd_q <= '0;
            end else begin
                if (load_wr)
                    wr_q <= wr_data[g*8 +: 8];
                if (capture)
                    rd_q <= lane_en[g] ? dq_in[g*8 +: 8] : 8'h00;
            end
        end

        assign dq_out[g*8 +: 8]  = wr_q;
        assign rd_data[g*8 +: 8] = rd_q;
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CLK_NS    = 10,
    parameter int T_WC_NS   = 55,
    parameter int T_PWE_NS  = 40,
    parameter int T_AW_NS   = 45,
    parameter int T_SD_NS   = 25,
    parameter int T_AA_NS   = 55,
    parameter int T_DOE_NS  = 25,
    parameter int T_RC_NS   = 55,
    parameter int T_HZOE_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_bmask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_out,
    input  logic [15:0]       mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int LANES      = 2;
    localparam int C_WC       = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int C_PWE      = ns_to_cycles(T_PWE_NS, CLK_NS);
    localparam int C_AW       = ns_to_cycles(T_AW_NS, CLK_NS);
    localparam int C_SD       = ns_to_cycles(T_SD_NS, CLK_NS);
    localparam int C_AA       = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int C_DOE      = ns_to_cycles(T_DOE_NS, CLK_NS);
    localparam int C_RC       = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int C_HZ       = ns_to_cycles(T_HZOE_NS, CLK_NS);
    // The setup cycle already carries a valid address, hence C_AW-1.
    localparam int STROBE_CYC = imax(imax(C_PWE, C_SD), C_AW - 1);
    localparam int REC_CYC    = imax(0, C_WC - STROBE_CYC - 2);
    localparam int RD_CYC     = imax(imax(C_AA, C_DOE), C_RC);
    localparam int TURN_CYC   = C_HZ;
    localparam int LONGEST    = imax(imax(STROBE_CYC, RD_CYC), imax(REC_CYC, TURN_CYC));
    localparam int CNT_W      = $clog2(LONGEST + 1);

    bus_state_t        state_q, state_d;
    logic              phase_last;
    logic              timer_load;
    logic [CNT_W-1:0]  phase_len;
    logic              accept;
    logic              capture;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        mask_q;
    logic              sel;

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign capture    = (state_q == ST_RD_ACCESS) && phase_last;
    assign timer_load = (state_d != state_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            mask_q    <= '0;
            rsp_valid <= 1'b0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= capture;
            if (accept) begin
                addr_q <= req_addr;
                mask_q <= req_bmask;
            end
        end
    end

    // Next state and length of the phase being entered
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_WR_SETUP:   if (phase_last) state_d = ST_WR_STROBE;
            ST_WR_STROBE:  if (phase_last) state_d = ST_WR_HOLD;
            ST_WR_HOLD:    if (phase_last) state_d = (REC_CYC > 0) ? ST_WR_RECOVER : ST_IDLE;
            ST_WR_RECOVER: if (phase_last) state_d = ST_IDLE;
            ST_RD_ACCESS:  if (phase_last) state_d = ST_RD_TURN;
            ST_RD_TURN:    if (phase_last) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase

        unique case (state_d)
            ST_WR_STROBE:  phase_len = CNT_W'(STROBE_CYC);
            ST_WR_RECOVER: phase_len = CNT_W'(REC_CYC);
            ST_RD_ACCESS:  phase_len = CNT_W'(RD_CYC);
            ST_RD_TURN:    phase_len = CNT_W'(TURN_CYC);
            default:       phase_len = CNT_W'(1);
        endcase
    end

    // Pin decode
    always_comb begin
        sel       = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:       req_ready = 1'b1;
            ST_WR_SETUP:   begin sel = 1'b1; mem_dq_oe = 1'b1; end
            ST_WR_STROBE:  begin sel = 1'b1; mem_dq_oe = 1'b1; mem_we_n = 1'b0; end
            ST_WR_HOLD:    begin sel = 1'b1; mem_dq_oe = 1'b1; end
            ST_WR_RECOVER: ;
            ST_RD_ACCESS:  begin sel = 1'b1; mem_oe_n = 1'b0; end
            ST_RD_TURN:    ;
            default:       ;
        endcase
        mem_cs1_n = ~sel;
        mem_cs2   = sel;
        mem_lb_n  = ~(sel & mask_q[0]);
        mem_ub_n  = ~(sel & mask_q[1]);
    end

    assign mem_addr = addr_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (phase_len),
        .last     (phase_last)
    );

    sram_lane_path #(.LANES(LANES)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_wr  (accept && req_write),
        .wr_data  (req_wdata),
        .capture  (capture),
        .lane_en  (mask_q),
        .dq_in    (mem_dq_in),
        .dq_out   (mem_dq_out),
        .rd_data  (rsp_rdata)
    );

    // R9
    no_we_oe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
    // R9
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    // R4
    drive_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_dq_oe));
    // R4
    drive_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);
    // R4
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_cs1_n && mem_cs2));
    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !mem_dq_oe);
    // R5
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R5
    rsp_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));
    // R2
    parked_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/tb_sram_bus_ctrl.sv
module tb_sram_bus_ctrl;

    localparam int E_WR_BUSY  = 6;
    localparam int E_RD_BUSY  = 8;
    localparam int E_STROBE   = 4;
    localparam int E_RD_OE    = 6;
    localparam int E_TURN     = 2;
    localparam int E_SEL      = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_dq_oe;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [15:0] ref_mem [1024];
    logic [15:0] pin_mem [1024];

    always #5 clk = ~clk;

    sram_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    function automatic int idx(input logic [15:0] a);
        return int'({a[15], a[8:0]});
    endfunction

    function automatic logic [15:0] lane_bits(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [15:0] expect_read(input logic [15:0] a, input logic [1:0] m);
        return ref_mem[idx(a)] & lane_bits(m);
    endfunction

    // Pin-level memory: reads when selected with OE low, garbage on idle lanes
    always_comb begin
        mem_dq_in = 16'hA5C3;
        if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = pin_mem[idx(mem_addr)][7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = pin_mem[idx(mem_addr)][15:8];
        end
    end

    // Pin-level memory: stores while every write strobe overlaps
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && !mem_cs1_n && mem_cs2 && !mem_we_n) begin
            if (!mem_lb_n) pin_mem[idx(mem_addr)][7:0]  <= mem_dq_oe ? mem_dq_out[7:0]  : 8'hxx;
            if (!mem_ub_n) pin_mem[idx(mem_addr)][15:8] <= mem_dq_oe ? mem_dq_out[15:8] : 8'hxx;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        int busy = 0, we_low = 0, drv = 0, oe_low = 0, oe_in_wr = 0, sel = 0;
        int lb_low = 0, ub_low = 0, rsp_cnt = 0, turn = 0, fight = 0;
        int first_ok = 0, last_ok = 0;
        logic [15:0] got = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) begin
            busy++;
            if (!mem_we_n) we_low++;
            if (mem_dq_oe) drv++;
            if (!mem_oe_n) oe_low++;
            if (wr && !mem_oe_n) oe_in_wr++;
            if (!mem_cs1_n && mem_cs2) sel++;
            if (!mem_lb_n) lb_low++;
            if (!mem_ub_n) ub_low++;
            if ((!mem_we_n && !mem_oe_n) || (mem_dq_oe && !mem_oe_n)) fight++;
            if (!wr && busy > E_RD_OE && !mem_dq_oe) turn++;
            if (busy == 1 && mem_dq_oe && mem_we_n) first_ok = 1;
            if (busy == E_WR_BUSY && mem_dq_oe && mem_we_n) last_ok = 1;
            if (rsp_valid) begin rsp_cnt++; got = rsp_rdata; end
            @(negedge clk);
        end
        chk("R2", "selected cycles", sel, E_SEL);
        chk("R3", "lower lane cycles", lb_low, m[0] ? E_SEL : 0);
        chk("R3", "upper lane cycles", ub_low, m[1] ? E_SEL : 0);
        chk("R9", "overlap cycles", fight, 0);
        if (wr) begin
            chk("R7", "write busy", busy, E_WR_BUSY);
            chk("R4", "we low cycles", we_low, E_STROBE);
            chk("R4", "driver cycles", drv, E_STROBE + 2);
            chk("R4", "oe low in write", oe_in_wr, 0);
            chk("R4", "driver lead/lag", first_ok + last_ok, 2);
            if (m[0]) ref_mem[idx(a)][7:0]  = d[7:0];
            if (m[1]) ref_mem[idx(a)][15:8] = d[15:8];
        end else begin
            chk("R7", "read busy", busy, E_RD_BUSY);
            chk("R5", "oe low cycles", oe_low, E_RD_OE);
            chk("R5", "rsp pulses", rsp_cnt, 1);
            chk("R6", "turnaround cycles", turn, E_TURN);
            chk("R8", "read data", int'(got), int'(expect_read(a, m)));
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            ref_mem[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
            pin_mem[i] = ref_mem[i];
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", "cs1_n", int'(mem_cs1_n), 1);
        chk("R1", "cs2", int'(mem_cs2), 0);
        chk("R1", "we/oe", int'({mem_we_n, mem_oe_n}), 3);
        chk("R1", "lanes", int'({mem_lb_n, mem_ub_n}), 3);
        chk("R1", "dq_oe/rsp", int'({mem_dq_oe, rsp_valid}), 0);
        chk("R1", "ready", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        do_req(1'b1, 16'h0000, 16'h1234, 2'b11);
        do_req(1'b0, 16'h0000, 16'h0000, 2'b11);
        do_req(1'b1, 16'hFFFF, 16'hBEEF, 2'b01);   // R3 lower lane only
        do_req(1'b0, 16'hFFFF, 16'h0000, 2'b11);
        do_req(1'b1, 16'hFFFF, 16'hCAFE, 2'b10);   // R3 upper lane only
        do_req(1'b0, 16'hFFFF, 16'h0000, 2'b11);
        do_req(1'b1, 16'h0042, 16'h7777, 2'b00);   // R3 empty mask: no change
        do_req(1'b0, 16'h0042, 16'h0000, 2'b11);
        do_req(1'b0, 16'h0000, 16'h0000, 2'b01);   // R5 upper lane reads zero
        do_req(1'b0, 16'h0000, 16'h0000, 2'b10);   // R5 lower lane reads zero

        // Constrained random
        for (int n = 0; n < 300; n++) begin
            logic [15:0] a;
            a = 16'($urandom_range(0, 31)) | (($urandom & 1) != 0 ? 16'h8000 : 16'h0);
            do_req(1'($urandom & 1), a, 16'($urandom), 2'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule